// File: doc/BRIEF.md
# Next-PC Branch and Jump Unit

This block picks the address the fetch stage uses after the current instruction of a 32-bit RISC core. Each cycle it receives the address of the instruction now in decode, a jump kind already decoded from that instruction, a register operand, a 28-bit immediate offset, a branch constant and the live flags register. From these it returns the next fetch address, a taken flag and a link value with its write enable for register 15.

Six behaviours are supported: plain sequential fetch, an unconditional jump to a register address, an unconditional jump relative to the instruction's own address, a conditional branch taken only when the whole flags word equals the constant, a call that jumps to a register and links, and a return that jumps to the saved return address. The core executes the instruction that follows any jump or branch (a delay slot). For that reason the link value skips that slot: it is the call's own address plus 8. A relative jump with offset -4 lands on itself, and the core uses that as its halt idiom. The unit is purely combinational and holds no state, so it can sit between decode and the fetch address register without adding latency.

Top module: `nxpc_unit`

## Requirements
- R1: When the jump kind is 0 (sequential) or an unused code (6, 7), next_pc is pc_cur + 4 and both taken and link_wr are 0.
- R2: Jump kind 1 (register jump) gives next_pc = reg_op and taken = 1, whatever the flags hold.
- R3: Jump kind 2 (relative jump) gives next_pc = pc_cur + 4 + the sign-extended 28-bit imm_off, with taken = 1. An offset of -4 (0xFFFFFFC) makes next_pc equal pc_cur.
- R4: Jump kind 3 (conditional branch) gives next_pc = reg_op and taken = 1 when every bit of flags equals br_const. On any mismatch it gives next_pc = pc_cur + 4 and taken = 0.
- R5: Jump kind 4 (call) gives next_pc = reg_op, taken = 1 and link_wr = 1, with link_val = pc_cur + 8.
- R6: Jump kind 5 (return) gives next_pc = reg_op, taken = 1 and link_wr = 0. The pipeline supplies the content of register 15 on reg_op.
- R7: link_wr is 1 only for jump kind 4. link_val always equals pc_cur + 8.
- R8: All address arithmetic wraps modulo 2^32. For example, pc_cur = 0xFFFFFFFC gives a sequential next_pc of 0 and a link_val of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_cur | input | 32 | Address of the instruction being decoded |
| jump_kind | input | 3 | Decoded jump kind: 0 seq, 1 reg jump, 2 relative, 3 branch, 4 call, 5 return |
| reg_op | input | 32 | Register operand used as jump target |
| imm_off | input | 28 | Signed offset for the relative jump |
| br_const | input | 8 | Constant that flags must equal for a branch |
| flags | input | 8 | Current flags register |
| next_pc | output | 32 | Next fetch address |
| taken | output | 1 | Control flow leaves the sequential path |
| link_wr | output | 1 | Write enable of the return address into register 15 |
| link_val | output | 32 | Return address (pc_cur + 8) |

## Verification
The immediate assertions take for granted that all inputs hold settled, known values whenever the block evaluates. They also assume that the decoder only presents jump kinds from the three-bit code set above, with undefined codes treated as sequential. The bench keeps to this by changing every input together inside a single task step, away from the clock edge, and only then sampling. It also drives the unused codes on purpose, so that the sequential fallback is exercised. Targets are written as full 32-bit register values, since the unit neither aligns nor checks them.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_SEQ  = 3'd0,
    K_JREG = 3'd1,
    K_JREL = 3'd2,
    K_BRFL = 3'd3,
    K_CALL = 3'd4,
    K_RET  = 3'd5
  } kind_e;

  function automatic logic kind_is_uncond(input logic [KIND_W-1:0] k);
    return (k == K_JREG) || (k == K_JREL) || (k == K_CALL) || (k == K_RET);
  endfunction
endpackage

// File: rtl/nxpc_addr.sv
module nxpc_addr #(
  parameter int XLEN  = 32,
  parameter int OFFW  = 28,
  parameter int ISTEP = 4
) (
  input  logic [XLEN-1:0] pc_cur,
  input  logic [OFFW-1:0] imm_off,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] rel_pc,
  output logic [XLEN-1:0] lnk_pc
);
  localparam logic [XLEN-1:0] STEP1    = XLEN'(ISTEP);
  localparam logic [XLEN-1:0] STEP2    = XLEN'(2 * ISTEP);
  localparam logic [OFFW-1:0] SELF_OFF = '0 - OFFW'(ISTEP);

  function automatic logic [XLEN-1:0] widen_off(input logic [OFFW-1:0] o);
    return {{(XLEN-OFFW){o[OFFW-1]}}, o};
  endfunction

  function automatic logic [XLEN-1:0] step_from(input logic [XLEN-1:0] base,
                                                input logic [XLEN-1:0] inc);
    return base + inc;
  endfunction

  always_comb begin
    seq_pc = step_from(pc_cur, STEP1);
    rel_pc = step_from(seq_pc, widen_off(imm_off));
    lnk_pc = step_from(pc_cur, STEP2);
    if (imm_off == SELF_OFF) begin
      AST_SELF_LOOP: assert (rel_pc == pc_cur); // R3
    end
    AST_LINK_PAST_SLOT: assert ((lnk_pc - seq_pc) == STEP1); // R7
  end
endmodule

// File: rtl/nxpc_cond.sv
module nxpc_cond #(
  parameter int FLAGW = 8
) (
  input  logic [FLAGW-1:0] flags,
  input  logic [FLAGW-1:0] br_const,
  output logic             match
);
  logic [FLAGW-1:0] bit_eq;

  for (genvar i = 0; i < FLAGW; i++) begin : g_bit
    assign bit_eq[i] = ~(flags[i] ^ br_const[i]);
  end

  assign match = &bit_eq;
endmodule

// File: rtl/nxpc_sel.sv
module nxpc_sel
  import nxpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [KIND_W-1:0] kind,
  input  logic              match,
  input  logic [XLEN-1:0]   reg_op,
  input  logic [XLEN-1:0]   seq_pc,
  input  logic [XLEN-1:0]   rel_pc,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              link_wr
);
  always_comb begin
    next_pc = seq_pc;
    taken   = 1'b0;
    link_wr = 1'b0;
    case (kind_e'(kind))
      K_JREG: begin next_pc = reg_op; taken = 1'b1; end
      K_JREL: begin next_pc = rel_pc; taken = 1'b1; end
      K_BRFL: begin
        if (match) begin
          next_pc = reg_op;
          taken   = 1'b1;
        end
      end
      K_CALL: begin next_pc = reg_op; taken = 1'b1; link_wr = 1'b1; end
      K_RET:  begin next_pc = reg_op; taken = 1'b1; end
      default: ;
    endcase
    if (!taken) begin
      AST_FALLTHROUGH_SEQ: assert (next_pc == seq_pc); // R1
    end
    if (taken && (kind != K_JREL)) begin
      AST_REG_TARGET: assert (next_pc == reg_op); // R2
    end
  end
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
  import nxpc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFFW  = 28,
  parameter int FLAGW = 8,
  parameter int ISTEP = 4
) (
  input  logic [XLEN-1:0]   pc_cur,
  input  logic [KIND_W-1:0] jump_kind,
  input  logic [XLEN-1:0]   reg_op,
  input  logic [OFFW-1:0]   imm_off,
  input  logic [FLAGW-1:0]  br_const,
  input  logic [FLAGW-1:0]  flags,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              link_wr,
  output logic [XLEN-1:0]   link_val
);
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] rel_pc;
  logic            flag_match;

  nxpc_addr #(.XLEN(XLEN), .OFFW(OFFW), .ISTEP(ISTEP)) u_addr (
    .pc_cur (pc_cur),
    .imm_off(imm_off),
    .seq_pc (seq_pc),
    .rel_pc (rel_pc),
    .lnk_pc (link_val)
  );

  nxpc_cond #(.FLAGW(FLAGW)) u_cond (
    .flags   (flags),
    .br_const(br_const),
    .match   (flag_match)
  );

  nxpc_sel #(.XLEN(XLEN)) u_sel (
    .kind   (jump_kind),
    .match  (flag_match),
    .reg_op (reg_op),
    .seq_pc (seq_pc),
    .rel_pc (rel_pc),
    .next_pc(next_pc),
    .taken  (taken),
    .link_wr(link_wr)
  );

  always_comb begin
    if (kind_is_uncond(jump_kind)) begin
      AST_UNCOND_TAKEN: assert (taken); // R2
    end
    if ((jump_kind == K_BRFL) && (flags != br_const)) begin
      AST_BRANCH_MISS: assert (!taken); // R4
    end
    if (link_wr) begin
      AST_LINK_ONLY_CALL: assert (jump_kind == K_CALL && taken); // R5
    end
  end
endmodule

// File: tb/test_nxpc_unit.sv
module test_nxpc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_cur, reg_op;
  logic [2:0]  jump_kind;
  logic [27:0] imm_off;
  logic [7:0]  br_const, flags;
  logic [31:0] next_pc, link_val;
  logic        taken, link_wr;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nxpc_unit i_nxpc_unit (
    .pc_cur(pc_cur), .jump_kind(jump_kind), .reg_op(reg_op), .imm_off(imm_off),
    .br_const(br_const), .flags(flags), .next_pc(next_pc), .taken(taken),
    .link_wr(link_wr), .link_val(link_val)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] pc, input logic [2:0] k, input logic [31:0] r,
                       input logic [27:0] o, input logic [7:0] c, input logic [7:0] f);
    @(negedge clk);
    pc_cur = pc; jump_kind = k; reg_op = r; imm_off = o; br_const = c; flags = f;
    #1;
  endtask

  function automatic logic [31:0] exp_rel(input logic [31:0] pc, input logic [27:0] o);
    logic [31:0] ext;
    ext = o[27] ? {4'hF, o} : {4'h0, o};
    return pc + 32'd4 + ext;
  endfunction

  task automatic t_reset;
    drive(32'h0, 3'd0, 32'h0, 28'h0, 8'h0, 8'h0);
    chk("R1", "reset next_pc", next_pc, 32'h4);
    chk("R1", "reset taken", {31'b0, taken}, 32'h0);
    chk("R7", "reset link_wr", {31'b0, link_wr}, 32'h0);
  endtask

  task automatic t_seq;
    drive(32'h0000_1000, 3'd0, 32'hDEAD_BEEF, 28'h123, 8'h5, 8'h5);
    chk("R1", "seq next_pc", next_pc, 32'h0000_1004);
    chk("R1", "seq taken", {31'b0, taken}, 32'h0);
    for (int k = 6; k < 8; k++) begin
      drive(32'h0040_0020, 3'(k), 32'h1111_2222, 28'h0, 8'h0, 8'h0);
      chk("R1", "unused code next_pc", next_pc, 32'h0040_0024);
      chk("R1", "unused code taken", {31'b0, taken}, 32'h0);
      chk("R7", "unused code link_wr", {31'b0, link_wr}, 32'h0);
    end
  endtask

  task automatic t_jreg;
    drive(32'h0000_2000, 3'd1, 32'h0ABC_0010, 28'h0, 8'h1, 8'h2);
    chk("R2", "jreg next_pc", next_pc, 32'h0ABC_0010);
    chk("R2", "jreg taken", {31'b0, taken}, 32'h1);
    chk("R7", "jreg link_wr", {31'b0, link_wr}, 32'h0);
  endtask

  task automatic t_jrel;
    logic [27:0] offs [4] = '{28'h0000_100, 28'hFFF_FF00, 28'hFFF_FFFC, 28'h800_0000};
    for (int i = 0; i < 4; i++) begin
      drive(32'h1000_0400, 3'd2, 32'h5555_5555, offs[i], 8'h0, 8'h0);
      chk("R3", "jrel next_pc", next_pc, exp_rel(32'h1000_0400, offs[i]));
      chk("R3", "jrel taken", {31'b0, taken}, 32'h1);
    end
    drive(32'h0000_0ABC, 3'd2, 32'h0, 28'hFFF_FFFC, 8'h0, 8'h0);
    chk("R3", "self-loop next_pc", next_pc, 32'h0000_0ABC);
  endtask

  task automatic t_branch;
    drive(32'h0000_3000, 3'd3, 32'h0000_7000, 28'h0, 8'hA5, 8'hA5);
    chk("R4", "branch hit next_pc", next_pc, 32'h0000_7000);
    chk("R4", "branch hit taken", {31'b0, taken}, 32'h1);
    for (int b = 0; b < 8; b++) begin
      drive(32'h0000_3000, 3'd3, 32'h0000_7000, 28'h0, 8'hA5, 8'hA5 ^ (8'h1 << b));
      chk("R4", "branch miss next_pc", next_pc, 32'h0000_3004);
      chk("R4", "branch miss taken", {31'b0, taken}, 32'h0);
    end
  endtask

  task automatic t_call;
    drive(32'h0000_4000, 3'd4, 32'h0002_0000, 28'h0, 8'h0, 8'h0);
    chk("R5", "call next_pc", next_pc, 32'h0002_0000);
    chk("R5", "call taken", {31'b0, taken}, 32'h1);
    chk("R5", "call link_wr", {31'b0, link_wr}, 32'h1);
    chk("R5", "call link_val", link_val, 32'h0000_4008);
  endtask

  task automatic t_ret;
    drive(32'h0002_0010, 3'd5, 32'h0000_4008, 28'h0, 8'h0, 8'h0);
    chk("R6", "ret next_pc", next_pc, 32'h0000_4008);
    chk("R6", "ret taken", {31'b0, taken}, 32'h1);
    chk("R6", "ret link_wr", {31'b0, link_wr}, 32'h0);
    chk("R7", "ret link_val", link_val, 32'h0002_0018);
  endtask

  task automatic t_wrap;
    drive(32'hFFFF_FFFC, 3'd0, 32'h0, 28'h0, 8'h0, 8'h0);
    chk("R8", "wrap seq next_pc", next_pc, 32'h0);
    chk("R8", "wrap link_val", link_val, 32'h4);
    drive(32'hFFFF_FFF0, 3'd2, 32'h0, 28'h000_0020, 8'h0, 8'h0);
    chk("R8", "wrap rel next_pc", next_pc, 32'h0000_0014);
  endtask

  initial begin
    pc_cur = '0; jump_kind = '0; reg_op = '0; imm_off = '0; br_const = '0; flags = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_seq();
    t_jreg();
    t_jrel();
    t_branch();
    t_call();
    t_ret();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule